// File: doc/BRIEF.md
# Up/Down Counting Correlated Double Sampler for a Single-Slope Column Converter

This block is the digital half of one column of a single-slope image sensor converter. It removes each column's offset by subtracting in the counter itself. A conversion runs in two ramp phases. The block first opens a short window in which the ramp is compared with the pixel's reset level. It then opens a longer window in which the ramp is compared with the exposed pixel level. A single signed counter steps downward in the first window and upward in the second. What remains in the counter at the end is the difference between the two levels, with no separate subtractor.

The block produces the window timing itself. Its two window outputs tell the shared ramp generator when to sweep. The comparator input is high while the ramp has not yet reached the level under test. In each window the counter follows the comparator only up to the first cycle in which the comparator is seen low. After that cycle the count is frozen for the rest of the window, so later comparator chatter cannot change it. The net count is limited to the unsigned code range and is registered together with a one-cycle done pulse.

Top module: `updown_cds_counter`

## Requirements
- R1: A start pulse sampled while idle clears the count to zero and raises the reset-window output for exactly RST_CYC (default 256) cycles, starting the cycle after the start edge.
- R2: During the reset window, the count falls by one on each clock edge at which the comparator input is high (1 = ramp not yet crossed), until the first edge at which it is low.
- R3: The signal-window output rises in the cycle the reset window ends and stays high for exactly SIG_CYC (default 1024) cycles; the two window outputs are never high together.
- R4: During the signal window, the count rises by one on each clock edge at which the comparator input is high, until the first edge at which it is low.
- R5: Within a window, once the comparator has been sampled low, the count holds for the rest of that window even if the comparator returns high.
- R6: In the cycle after the last signal-window cycle, done is high for exactly one cycle and result carries the net count; result keeps that value until the next done pulse.
- R7: A net count below zero is reported as result 0.
- R8: A net count above 2^RES_W-1 (1023 by default) is reported as 1023.
- R9: A start pulse that arrives while a window is open is ignored and changes neither the window timing nor the result.
- R10: While reset is asserted and right after it, result is 0 and done and both window outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| cmp_i | input | 1 | Comparator, high while the ramp has not crossed the level |
| rst_win | output | 1 | High during the reset-level ramp window |
| sig_win | output | 1 | High during the signal-level ramp window |
| result | output | RES_W (10) | Clamped net count, registered at completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle by assertions: the windows never overlap, and the reset window hands over directly to the signal window. The done pulse lasts one cycle and coincides with the end of the signal window. The result changes only when done is high, and a frozen count stays unchanged within its window. Only the bench scenarios can show the arithmetic: the exact window lengths, the net count for chosen crossing points, clamping at both ends, and rejection of comparator chatter and of a start pulse during a conversion. The bench's cycle model follows the comparator stimulus it generates itself.

// File: rtl/updown_cds_counter.sv
module updown_cds_counter #(
  parameter int RES_W   = 10,
  parameter int RST_CYC = 256,
  parameter int SIG_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_i,
  output logic             rst_win,
  output logic             sig_win,
  output logic [RES_W-1:0] result,
  output logic             done
);

  localparam int TW   = $clog2(SIG_CYC);
  localparam int CW   = $clog2(RST_CYC + SIG_CYC) + 1;
  localparam int MAXV = (1 << RES_W) - 1;

  typedef enum logic [1:0] {IDLE, RWIN, SWIN} phase_t;

  phase_t               phase;
  logic [TW-1:0]        tmr;
  logic                 armed;
  logic signed [CW-1:0] cnt, cnt_nxt;
  logic                 step, r_last, s_last;

  assign step    = armed && cmp_i;
  assign r_last  = (tmr == TW'(RST_CYC - 1));
  assign s_last  = (tmr == TW'(SIG_CYC - 1));
  assign rst_win = (phase == RWIN);
  assign sig_win = (phase == SWIN);

  always_comb begin
    cnt_nxt = cnt;
    if (step && phase == RWIN) cnt_nxt = cnt - CW'(1);
    if (step && phase == SWIN) cnt_nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= IDLE;
      tmr    <= '0;
      armed  <= 1'b0;
      cnt    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (start) begin
          phase <= RWIN;
          tmr   <= '0;
          cnt   <= '0;
          armed <= 1'b1;
        end
        RWIN: begin
          cnt <= cnt_nxt;
          if (!cmp_i) armed <= 1'b0;
          if (r_last) begin
            phase <= SWIN;
            tmr   <= '0;
            armed <= 1'b1;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        SWIN: begin
          cnt <= cnt_nxt;
          if (!cmp_i) armed <= 1'b0;
          if (s_last) begin
            phase <= IDLE;
            tmr   <= '0;
            done  <= 1'b1;
            if (cnt_nxt < 0)
              result <= '0;
            else if (cnt_nxt > $signed(CW'(MAXV)))
              result <= RES_W'(MAXV);
            else
              result <= cnt_nxt[RES_W-1:0];
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end

  // R3
  win_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rst_win && sig_win));

  // R3
  win_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_win) |-> sig_win);

  // R1
  win_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_win) |-> $past(start));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(sig_win));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != IDLE && !armed && !r_last && !s_last) |=> $stable(cnt));

endmodule

// File: tb/test_updown_cds_counter.sv
module test_updown_cds_counter;
  localparam int RES_W = 10, RST_CYC = 256, SIG_CYC = 1024;

  logic clk = 0, rst = 1, start = 0, cmp_i = 0;
  logic rst_win, sig_win, done;
  logic [RES_W-1:0] result;

  int checks = 0, fails = 0, cycles = 0;
  int m_mode = 0, m_t = 0, m_cnt = 0, m_arm = 0, m_res = 0, m_done = 0;

  always #4 clk = ~clk;

  updown_cds_counter #(.RES_W(RES_W), .RST_CYC(RST_CYC), .SIG_CYC(SIG_CYC)) i_updown_cds_counter (
    .clk(clk), .rst(rst), .start(start), .cmp_i(cmp_i),
    .rst_win(rst_win), .sig_win(sig_win), .result(result), .done(done));

  function automatic int clampv(int v);
    if (v < 0) return 0;
    if (v > (1 << RES_W) - 1) return (1 << RES_W) - 1;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_mode = 0; m_t = 0; m_cnt = 0; m_arm = 0; m_res = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_mode == 0) begin
        if (start) begin m_mode = 1; m_t = 0; m_cnt = 0; m_arm = 1; end
      end else begin
        if (m_arm && cmp_i) m_cnt += (m_mode == 1) ? -1 : 1;
        else m_arm = 0;
        if (m_mode == 1 && m_t == RST_CYC - 1) begin
          m_mode = 2; m_t = 0; m_arm = 1;
        end else if (m_mode == 2 && m_t == SIG_CYC - 1) begin
          m_mode = 0; m_t = 0; m_res = clampv(m_cnt); m_done = 1;
        end else m_t++;
      end
    end
  end

  // per-cycle comparison (R1 R3 R6 R10)
  always @(negedge clk) begin
    chk("R1 rst_win", rst_win, m_mode == 1);
    chk("R3 sig_win", sig_win, m_mode == 2);
    chk("R6 done", done, m_done);
    chk("R6 result", result, m_res);
  end

  always @(posedge clk) if (cycles > 200000) begin
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected<=200000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic conv(string req, int xr, int xs, bit glitch, bit late_start, int exp);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < RST_CYC + SIG_CYC; i++) begin
      if (i < RST_CYC) cmp_i = (i < xr) || (glitch && i == xr + 3);
      else cmp_i = (i - RST_CYC < xs) || (glitch && i - RST_CYC == xs + 5);
      start = late_start && (i == 500);
      @(negedge clk);
    end
    start = 0;
    cmp_i = 0;
    chk({req, " final result"}, result, exp);
    chk({req, " done"}, done, 1);
    @(negedge clk);
    chk({req, " done one cycle"}, done, 0);
    chk({req, " result held"}, result, exp);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk("R10 result", result, 0);
    chk("R10 done", done, 0);
    chk("R10 windows", rst_win | sig_win, 0);
    rst = 0;
    @(negedge clk);
    chk("R10 idle", rst_win | sig_win | done, 0);
    conv("R2 R4 basic", 40, 600, 0, 0, 560);
    conv("R8 overflow", 0, 1024, 0, 0, 1023);
    conv("R7 negative", 256, 100, 0, 0, 0);
    conv("R5 chatter", 10, 20, 1, 0, 10);
    conv("R9 busy start", 64, 300, 0, 1, 236);
    conv("R2 R4 equal", 123, 123, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule